// File: doc/BRIEF.md
# Two-Level Grouped Interrupt Controller

This block collects interrupt requests for a processor and routes them to one of two outputs: a normal interrupt line and a fast interrupt line. Thirty-two primary sources enter it. Five of those sources are not driven directly. Each of the five stands for a group of secondary sub-sources, thirteen sub-sources in total. A sub-source latches into its own pending register. It reaches its parent source only while its bit in the sub-source mask is clear.

Every primary source has a pending latch, a mask bit (1 = blocked) and a routing bit (0 = normal line, 1 = fast line). While no interrupt is in service, the controller picks the lowest-numbered source that is pending, unmasked and routed to the normal line. It marks that source in a one-hot in-service register and publishes the source's number in a read-only index register. Software reads the index. It then clears, in order, the sub-source pending bits of that source, the source pending bit and the in-service bit. All three pending registers are write-one-to-clear.

Top module: `irqc_two_level`

## Requirements
- R1: After reset the routing register reads 0, the source mask reads 0xFFFFFFFF, the sub-source mask reads 0x1FFF, all pending registers and the index register read 0, and both interrupt outputs are low.
- R2: A sub-source pending bit sets on the cycle after its request input is high, whatever its mask. Writing to the sub-source pending register (word 5) clears exactly the bits written as 1. The sub-source numbers map to parents as follows: 0-2 go to source 28, 3-5 to source 23, 6-8 to source 15, 9-10 to source 31, and 11-12 to source 6.
- R3: A grouped source (6, 15, 23, 28, 31) sets its pending bit only from a pending sub-source of its group whose sub-source mask bit is 0. Its own request input is ignored.
- R4: A non-grouped source pending bit sets while its request input is high. If the request is still high when the bit is cleared, the bit reads set again.
- R5: Writing to the source pending register (word 0) or the in-service register (word 3) clears only the bits written as 1. Other bits are left as they were.
- R6: While the in-service register is zero, the lowest-numbered source that is pending, unmasked and in normal mode is marked in it. At most one bit is ever set, and that bit holds until software clears it.
- R7: The index register (word 4) reads the bit number of the in-service bit. It keeps its last value once that bit is cleared.
- R8: The normal interrupt output is high exactly while the in-service register is nonzero.
- R9: The fast interrupt output is high while any pending, unmasked source has routing bit 1. Such a source is never marked in service.
- R10: The register words are: 0 source pending, 1 routing, 2 source mask, 3 in-service, 4 index, 5 sub-source pending, 6 sub-source mask. Routing and both masks read back what was written.
- R11: Writes to the index register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 32 | Level requests of the primary sources |
| sub_req | input | 13 | Level requests of the sub-sources |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
Two functions can fall in the same cycle: a request that sets a pending bit, and a write-one-to-clear on that same bit. A source request is held high across the clearing write, and the pending bit must read set afterwards. A second pair is a new pending source arriving while another source is in service, and the clearing of the in-service bit. The bench raises a lower-numbered source while a higher one is in service. It checks that the in-service bit holds, and that the lower number is picked only once the current one is cleared. Random masks, routings and request patterns are then served one after another, in the order predicted by a bench function.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NUM_SRC = 32;
    localparam int NUM_SUB = 13;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int ADDR_W  = 3;

    // parent source numbers of the grouped sources
    localparam int PAR_CAM   = 6;
    localparam int PAR_UART2 = 15;
    localparam int PAR_UART1 = 23;
    localparam int PAR_UART0 = 28;
    localparam int PAR_ADC   = 31;

    // register word indices
    localparam logic [ADDR_W-1:0] A_SRC_PEND = 3'd0;
    localparam logic [ADDR_W-1:0] A_ROUTE    = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK     = 3'd2;
    localparam logic [ADDR_W-1:0] A_INSVC    = 3'd3;
    localparam logic [ADDR_W-1:0] A_INDEX    = 3'd4;
    localparam logic [ADDR_W-1:0] A_SUB_PEND = 3'd5;
    localparam logic [ADDR_W-1:0] A_SUB_MASK = 3'd6;

    function automatic int sub_parent(int s);
        if (s < 3)       return PAR_UART0;
        else if (s < 6)  return PAR_UART1;
        else if (s < 9)  return PAR_UART2;
        else if (s < 11) return PAR_ADC;
        else             return PAR_CAM;
    endfunction

    function automatic logic [NUM_SUB-1:0] members_of(int p);
        logic [NUM_SUB-1:0] m;
        m = '0;
        for (int s = 0; s < NUM_SUB; s++)
            if (sub_parent(s) == p) m[s] = 1'b1;
        return m;
    endfunction

    typedef struct packed {
        logic [NUM_SRC-1:0] src_pend;
        logic [NUM_SRC-1:0] route;
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] insvc;
        logic [IDX_W-1:0]   index;
        logic [NUM_SUB-1:0] sub_mask;
    } ctl_state_t;
endpackage

// File: rtl/irqc_sub_stage.sv
module irqc_sub_stage
    import irqc_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int NSUB = NUM_SUB
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSUB-1:0] sub_req,
    input  logic [NSUB-1:0] sub_clr,
    input  logic [NSUB-1:0] sub_mask,
    output logic [NSUB-1:0] sub_pend,
    output logic [NSRC-1:0] grp_req,
    output logic [NSRC-1:0] grp_member
);
    logic [NSUB-1:0] sub_pend_d, sub_pend_q;
    logic [NSUB-1:0] live;

    always_comb begin
        sub_pend_d = (sub_pend_q & ~sub_clr) | sub_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sub_pend_q <= '0;
        else        sub_pend_q <= sub_pend_d;
    end

    assign live     = sub_pend_q & ~sub_mask;
    assign sub_pend = sub_pend_q;

    for (genvar p = 0; p < NSRC; p++) begin : g_parent
        localparam logic [NSUB-1:0] MEMBERS = NSUB'(members_of(p));
        assign grp_req[p]    = |(live & MEMBERS);
        assign grp_member[p] = |MEMBERS;
    end

    // R2: a raised request is latched on the next edge
    p_sub_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_req != '0) |=> ((sub_pend_q & $past(sub_req)) == $past(sub_req)));

    // R2: cleared bits with no live request drop
    p_sub_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_clr != '0 && (sub_req & sub_clr) == '0) |=> ((sub_pend_q & $past(sub_clr)) == '0));
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
    parameter int NSRC  = 32,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  cand,
    output logic             found,
    output logic [IDX_W-1:0] index,
    output logic [NSRC-1:0]  onehot
);
    always_comb begin
        found = 1'b0;
        index = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                index = IDX_W'(i);
            end
        end
        onehot = found ? (NSRC'(1) << index) : '0;
    end
endmodule

// File: rtl/irqc_two_level.sv
module irqc_two_level
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SUB-1:0] sub_req,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_o,
    output logic               fiq_o
);
    ctl_state_t st_d, st_q;

    logic [NUM_SUB-1:0] sub_clr, sub_pend;
    logic [NUM_SRC-1:0] grp_req, grp_member, src_set, eligible, pick_onehot;
    logic [NUM_SRC-1:0] clr_src, clr_insvc;
    logic [IDX_W-1:0]   pick_index;
    logic               pick_found;

    assign sub_clr   = (bus_wr && bus_addr == A_SUB_PEND) ? bus_wdata[NUM_SUB-1:0] : '0;
    assign clr_src   = (bus_wr && bus_addr == A_SRC_PEND) ? bus_wdata[NUM_SRC-1:0] : '0;
    assign clr_insvc = (bus_wr && bus_addr == A_INSVC)    ? bus_wdata[NUM_SRC-1:0] : '0;

    irqc_sub_stage #(.NSRC(NUM_SRC), .NSUB(NUM_SUB)) u_sub (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_req   (sub_req),
        .sub_clr   (sub_clr),
        .sub_mask  (st_q.sub_mask),
        .sub_pend  (sub_pend),
        .grp_req   (grp_req),
        .grp_member(grp_member)
    );

    assign src_set  = (grp_member & grp_req) | (~grp_member & src_req);
    assign eligible = st_q.src_pend & ~st_q.mask & ~st_q.route;

    irqc_pick #(.NSRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .cand  (eligible),
        .found (pick_found),
        .index (pick_index),
        .onehot(pick_onehot)
    );

    always_comb begin
        st_d = st_q;
        st_d.src_pend = (st_q.src_pend & ~clr_src) | src_set;
        if (bus_wr) begin
            case (bus_addr)
                A_ROUTE:    st_d.route    = bus_wdata[NUM_SRC-1:0];
                A_MASK:     st_d.mask     = bus_wdata[NUM_SRC-1:0];
                A_SUB_MASK: st_d.sub_mask = bus_wdata[NUM_SUB-1:0];
                default: ;
            endcase
        end
        if (st_q.insvc == '0) begin
            if (pick_found) begin
                st_d.insvc = pick_onehot;
                st_d.index = pick_index;
            end
        end else begin
            st_d.insvc = st_q.insvc & ~clr_insvc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.src_pend <= '0;
            st_q.route    <= '0;
            st_q.mask     <= '1;
            st_q.insvc    <= '0;
            st_q.index    <= '0;
            st_q.sub_mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (bus_addr)
            A_SRC_PEND: bus_rdata = st_q.src_pend;
            A_ROUTE:    bus_rdata = st_q.route;
            A_MASK:     bus_rdata = st_q.mask;
            A_INSVC:    bus_rdata = st_q.insvc;
            A_INDEX:    bus_rdata = 32'(st_q.index);
            A_SUB_PEND: bus_rdata = 32'(sub_pend);
            A_SUB_MASK: bus_rdata = 32'(st_q.sub_mask);
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_o = |st_q.insvc;
    assign fiq_o = |(st_q.src_pend & ~st_q.mask & st_q.route);

    // R6: never more than one source in service
    p_insvc_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.insvc));

    // R6: an empty in-service register takes the lowest eligible bit
    p_pick_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.insvc == '0 && eligible != '0) |=>
        (st_q.insvc == ($past(eligible) & (~$past(eligible) + 1'b1))));

    // R6: the in-service bit holds unless it is cleared
    p_insvc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.insvc != '0 && (clr_insvc & st_q.insvc) == '0) |=> $stable(st_q.insvc));

    // R7: the index names the in-service bit
    p_index_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.insvc != '0) |-> st_q.insvc[st_q.index]);

    // R9: a fast-routed source never enters service
    p_no_fast_pick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ((st_q.insvc & $past(st_q.route)) == '0));

    // R4: a held plain request keeps its pending bit set
    p_level_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_req & ~grp_member) != '0) |=>
        ((st_q.src_pend & $past(src_req & ~grp_member)) == $past(src_req & ~grp_member)));
endmodule

// File: tb/irqc_two_level_bench.sv
module irqc_two_level_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] GRP_BITS = (32'd1 << 6) | (32'd1 << 15) | (32'd1 << 23)
                                     | (32'd1 << 28) | (32'd1 << 31);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_req = '0;
    logic [12:0] sub_req = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_two_level u_irqc_two_level (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .sub_req(sub_req),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    function automatic logic [31:0] lowest_bit(logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return 32'd1 << i;
        return '0;
    endfunction

    function automatic int lowest_idx(logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic pulse_src(logic [31:0] p);
        @(negedge clk); src_req = p;
        @(negedge clk); src_req = '0;
    endtask

    task automatic pulse_sub(logic [12:0] p);
        @(negedge clk); sub_req = p;
        @(negedge clk); sub_req = '0;
    endtask

    task automatic serve(int idx);
        wr(3'd0, 32'd1 << idx);
        wr(3'd3, 32'd1 << idx);
        idle(2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] pat, msk, rte, elig, fast;
        void'($urandom(32'd12345));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(3'd1, 32'h0, "R1 route");
        rd(3'd2, 32'hFFFF_FFFF, "R1 mask");
        rd(3'd6, 32'h1FFF, "R1 submask");
        rd(3'd0, 32'h0, "R1 srcpend");
        rd(3'd3, 32'h0, "R1 insvc");
        rd(3'd4, 32'h0, "R1 index");
        rd(3'd5, 32'h0, "R1 subpend");
        check("R1 irq", 32'(irq_o), 32'h0);
        check("R1 fiq", 32'(fiq_o), 32'h0);

        // R10 read-back
        wr(3'd1, 32'hA5A5_0000); rd(3'd1, 32'hA5A5_0000, "R10 route");
        wr(3'd1, 32'h0);
        wr(3'd6, 32'h0F0F);      rd(3'd6, 32'h0F0F, "R10 submask");
        wr(3'd6, 32'h1FFF);

        // R2 latch regardless of mask; R3 masked sub does not reach parent
        pulse_sub(13'h0010); idle(2);
        rd(3'd5, 32'h10, "R2 subpend set while masked");
        rd(3'd0, 32'h0, "R3 masked sub blocked");
        wr(3'd6, 32'h1FFF & ~32'h10); idle(2);
        rd(3'd0, 32'd1 << 23, "R3 unmasked sub sets parent 23");
        pulse_sub(13'h0011); idle(1);
        wr(3'd5, 32'h10); idle(1);
        rd(3'd5, 32'h01, "R2 w1c single sub bit");
        wr(3'd6, 32'h1FFF); wr(3'd5, 32'h1FFF); wr(3'd0, 32'hFFFF_FFFF); idle(1);
        rd(3'd0, 32'h0, "R3 parent cleared");

        // R3 grouped source ignores its own request
        pulse_src(32'd1 << 6); idle(2);
        rd(3'd0, 32'h0, "R3 grouped request ignored");

        // R4 level retrigger, R5 selective clear
        @(negedge clk); src_req = 32'h8; idle(2);
        wr(3'd0, 32'h8); idle(1);
        rd(3'd0, 32'h8, "R4 retrigger while held");
        src_req = '0;
        pulse_src(32'h20);
        wr(3'd0, 32'h8); idle(1);
        rd(3'd0, 32'h20, "R5 srcpend clears only written bit");
        wr(3'd0, 32'h20); idle(1);
        rd(3'd0, 32'h0, "R4 cleared after release");

        // R6/R7/R8 priority and hold
        wr(3'd2, ~((32'd1 << 5) | (32'd1 << 9) | (32'd1 << 2)));
        pulse_src((32'd1 << 5) | (32'd1 << 9)); idle(2);
        rd(3'd3, 32'd1 << 5, "R6 lowest picked");
        rd(3'd4, 32'd5, "R7 index 5");
        check("R8 irq high", 32'(irq_o), 32'h1);
        pulse_src(32'd1 << 2); idle(2);
        rd(3'd3, 32'd1 << 5, "R6 holds while in service");
        wr(3'd3, 32'd1 << 9); idle(1);
        rd(3'd3, 32'd1 << 5, "R5 insvc wrong bit kept");
        serve(5);
        rd(3'd3, 32'd1 << 2, "R6 next lower picked");
        rd(3'd4, 32'd2, "R7 index 2");
        serve(2);
        rd(3'd4, 32'd9, "R7 index 9");
        serve(9);
        rd(3'd3, 32'h0, "R6 insvc empty");
        check("R8 irq low", 32'(irq_o), 32'h0);
        rd(3'd4, 32'd9, "R7 index kept");
        wr(3'd4, 32'h1F); idle(1);
        rd(3'd4, 32'd9, "R11 index write ignored");

        // R9 fast routing
        wr(3'd1, 32'd1 << 10); wr(3'd2, ~(32'd1 << 10));
        pulse_src(32'd1 << 10); idle(2);
        check("R9 fiq high", 32'(fiq_o), 32'h1);
        rd(3'd3, 32'h0, "R9 fast source not in service");
        wr(3'd0, 32'd1 << 10); idle(1);
        check("R9 fiq low", 32'(fiq_o), 32'h0);
        wr(3'd1, 32'h0);

        // random phase
        for (int it = 0; it < 25; it++) begin
            wr(3'd2, 32'hFFFF_FFFF);
            wr(3'd0, 32'hFFFF_FFFF);
            wr(3'd3, 32'hFFFF_FFFF);
            idle(1);
            pat = $urandom() & ~GRP_BITS;
            msk = $urandom();
            rte = $urandom() & $urandom();
            wr(3'd1, rte);
            wr(3'd2, msk);
            pulse_src(pat); idle(2);
            elig = pat & ~msk & ~rte;
            fast = pat & ~msk & rte;
            rd(3'd0, pat, "R4 random srcpend");
            rd(3'd3, lowest_bit(elig), "R6 random pick");
            check("R8 random irq", 32'(irq_o), 32'(elig != 0));
            check("R9 random fiq", 32'(fiq_o), 32'(fast != 0));
            while (elig != 0) begin
                int k;
                k = lowest_idx(elig);
                rd(3'd4, 32'(k), "R7 random index");
                serve(k);
                elig = elig & ~(32'd1 << k);
                rd(3'd3, lowest_bit(elig), "R6 random next pick");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule